// File: doc/BRIEF.md
# Converter Sequencing and Status Control

This block holds the digital control around an analog-to-digital converter. Software reaches one byte-wide control and status register through a simple synchronous write port. The register is always visible on a read port. A programmable divider turns the system clock into a converter clock enable. A sequencer counts the converter clocks that a conversion takes.

When the count ends, the sequencer captures the sample on the behavioural converter data input into a result register. In the same edge it raises an end-of-conversion flag and drops the busy start bit. The flag is gated by an enable bit to form the interrupt request. The flag clears when software writes a one to it or when the interrupt controller pulses the acknowledge.

Conversions begin in one of two ways. In single mode, software writes the start bit. With auto-triggering on, a rising edge on an external trigger input also begins one. The first conversion after reset is a longer one that initializes the converter.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The register layout is start at bit 0, auto-trigger enable at bit 1, end-of-conversion flag at bit 2, interrupt enable at bit 3 and prescaler code at bits 6:4. Bit 7 reads zero. After reset the register and the result both read zero.
- R2: The converter clock enable is a one-cycle pulse. Its period in system clocks is 2, 2, 4, 8, 16, 32, 64 and 128 for prescaler codes 0 through 7.
- R3: A write that changes the prescaler code restarts the divider. The first enable pulse after such a write comes in the cycle that follows the write edge by (period - 1) cycles.
- R4: Writing a one to the start bit while idle begins a conversion. The start bit reads one until the conversion completes, and hardware then clears it.
- R5: Writing a zero to the start bit has no effect, neither on an idle block nor on a running conversion.
- R6: The first conversion after reset spans 25 converter clock enables. Every later conversion spans 13.
- R7: At completion, the result register takes the value on the converter data input and the flag is set in the same edge. A one-cycle done pulse accompanies them. At all other times the result holds its value.
- R8: The flag clears on a written one at bit 2 or on the acknowledge input. A written zero at bit 2 leaves it unchanged. A completion outranks a clear in the same cycle.
- R9: The interrupt request is high exactly when both the flag and the interrupt enable are one.
- R10: With auto-trigger on, a rising edge on the trigger input starts a conversion if none is running. With auto-trigger off, or while a conversion runs, a trigger edge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| trig | input | 1 | External trigger level; rising edge is used |
| irq_ack | input | 1 | Interrupt acknowledge pulse, clears the flag |
| conv_data | input | RES_W | Sample value offered by the converter |
| csr | output | 8 | Control and status register read value |
| result | output | RES_W | Last captured conversion result |
| cclk_en | output | 1 | Converter clock enable pulse |
| conv_done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take for granted that the converter data input is valid in the completion cycle. They also assume that writes and acknowledges are single-cycle strobes aligned to the system clock. The trigger must be a synchronous level that returns low between pulses, so that each rising edge is seen once. The bench drives every input at the falling edge and holds each write or acknowledge for exactly one rising edge. It lowers the trigger for at least one full cycle before raising it again, and it keeps the converter data constant across each conversion it checks.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int RES_W     = 10,
  parameter int NORM_CLKS = 13,
  parameter int INIT_CLKS = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             trig,
  input  logic             irq_ack,
  input  logic [RES_W-1:0] conv_data,
  output logic [7:0]       csr,
  output logic [RES_W-1:0] result,
  output logic             cclk_en,
  output logic             conv_done,
  output logic             irq
);
  localparam int CCW = $clog2(INIT_CLKS > NORM_CLKS ? INIT_CLKS : NORM_CLKS);

  logic           start_q, auto_q, flag_q, ie_q, init_done, trig_d;
  logic [2:0]     ps_q;
  logic [6:0]     dcnt, dlast;
  logic [7:0]     divf;
  logic [CCW-1:0] cc, last;
  logic           ps_chg, go, fin;

  assign divf    = 8'd1 << ((ps_q == 3'd0) ? 3'd1 : ps_q);
  assign dlast   = 7'(divf - 8'd1);
  assign cclk_en = (dcnt == dlast);
  assign ps_chg  = wr_en && (wr_data[6:4] != ps_q);
  assign last    = init_done ? CCW'(NORM_CLKS - 1) : CCW'(INIT_CLKS - 1);
  assign fin     = start_q && cclk_en && (cc == last);
  assign go      = !start_q && ((wr_en && wr_data[0]) || (auto_q && trig && !trig_d));

  assign csr       = {1'b0, ps_q, ie_q, flag_q, auto_q, start_q};
  assign conv_done = fin;
  assign irq       = flag_q & ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt <= '0;
    end else if (ps_chg || cclk_en) begin
      dcnt <= '0;
    end else begin
      dcnt <= dcnt + 7'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q   <= 1'b0;
      cc        <= '0;
      init_done <= 1'b0;
      trig_d    <= 1'b0;
      result    <= '0;
    end else begin
      trig_d <= trig;
      if (fin) begin
        start_q   <= 1'b0;
        cc        <= '0;
        init_done <= 1'b1;
        result    <= conv_data;
      end else if (go) begin
        start_q <= 1'b1;
        cc      <= '0;
      end else if (start_q && cclk_en) begin
        cc <= cc + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_q <= 1'b0;
      ie_q   <= 1'b0;
      ps_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_en) begin
        auto_q <= wr_data[1];
        ie_q   <= wr_data[3];
        ps_q   <= wr_data[6:4];
      end
      if (fin)
        flag_q <= 1'b1;
      else if (irq_ack || (wr_en && wr_data[2]))
        flag_q <= 1'b0;
    end
  end

  // R2
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dcnt <= dlast);

  // R6
  seq_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (cc <= last));

  // R7
  done_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> (csr[2] && !csr[0] && result == $past(conv_data)));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(result));

  // R5
  zero_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr[0] && !conv_done && wr_en && !wr_data[0]) |=> csr[0]);

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !conv_done) |=> !csr[2]);
endmodule

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
  localparam int CLK_PER = 10;
  localparam int RES_W = 10;
  localparam int PTAB [8] = '{2, 2, 4, 8, 16, 32, 64, 128};

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, trig = 1'b0, irq_ack = 1'b0;
  logic [7:0] wr_data = '0;
  logic [RES_W-1:0] conv_data = '0;
  logic [7:0] csr;
  logic [RES_W-1:0] result;
  logic cclk_en, conv_done, irq;
  int total = 0, bad = 0;

  adc_seq_ctrl #(.RES_W(RES_W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .trig(trig),
    .irq_ack(irq_ack), .conv_data(conv_data), .csr(csr), .result(result),
    .cclk_en(cclk_en), .conv_done(conv_done), .irq(irq));

  always #(CLK_PER/2) clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] cfg(bit st, bit au, bit fl, bit ie, logic [2:0] ps);
    return {1'b0, ps, ie, fl, au, st};
  endfunction

  task automatic wr(logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic run_ticks(output int n);
    n = 0;
    for (int k = 0; k < 20000 && csr[0]; k++) begin
      if (cclk_en) n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset csr", int'(csr), 0);
    chk("R1 reset result", int'(result), 0);
    chk("R9 reset irq", int'(irq), 0);

    for (int i = 0; i < 8; i++) begin
      wr(cfg(0, 0, 0, 0, 3'(i)));
      for (int k = 0; k < 300 && !cclk_en; k++) @(negedge clk);
      n = 0;
      for (int k = 0; k < 300; k++) begin
        @(negedge clk); n++;
        if (cclk_en) break;
      end
      chk($sformatf("R2 period code %0d", i), n, PTAB[i]);
    end
    chk("R1 layout prescale field", int'(csr), 8'h70);

    wr(cfg(0, 0, 0, 0, 3'd3));
    n = 0;
    for (int k = 0; k < 300 && !cclk_en; k++) begin n++; @(negedge clk); end
    chk("R3 restart after code change", n, 7);

    conv_data = 10'h2A5;
    wr(cfg(1, 0, 0, 1, 3'd0));
    chk("R4 start reads one", int'(csr[0]), 1);
    run_ticks(n);
    chk("R6 init conversion length", n, 25);
    chk("R4 start self-clears", int'(csr[0]), 0);
    chk("R7 result captured", int'(result), 10'h2A5);
    chk("R7 flag set", int'(csr[2]), 1);
    chk("R9 irq with enable", int'(irq), 1);

    wr(cfg(0, 0, 0, 1, 3'd0));
    chk("R8 written zero keeps flag", int'(csr[2]), 1);
    wr(cfg(0, 0, 0, 0, 3'd0));
    chk("R9 irq masked", int'(irq), 0);
    wr(cfg(0, 0, 1, 0, 3'd0));
    chk("R8 written one clears flag", int'(csr[2]), 0);

    wr(cfg(0, 0, 0, 0, 3'd0));
    chk("R5 zero start idle", int'(csr[0]), 0);

    conv_data = 10'h13C;
    wr(cfg(1, 0, 0, 0, 3'd0));
    run_ticks(n);
    chk("R6 normal conversion length", n, 13);
    chk("R7 second result", int'(result), 10'h13C);

    conv_data = 10'h0F0;
    wr(cfg(1, 0, 0, 0, 3'd0));
    wr(cfg(0, 0, 0, 0, 3'd0));
    chk("R5 zero start while busy", int'(csr[0]), 1);
    run_ticks(n);
    chk("R5 conversion still completes", int'(result), 10'h0F0);

    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk("R8 ack clears flag", int'(csr[2]), 0);

    conv_data = 10'h3FF;
    repeat (20) @(negedge clk);
    chk("R7 result holds", int'(result), 10'h0F0);

    pulse_trig();
    repeat (4) @(negedge clk);
    chk("R10 trigger ignored when auto off", int'(csr[0]), 0);

    wr(cfg(0, 1, 0, 0, 3'd0));
    conv_data = 10'h155;
    pulse_trig();
    chk("R10 trigger starts conversion", int'(csr[0]), 1);
    pulse_trig();
    run_ticks(n);
    repeat (4) @(negedge clk);
    chk("R10 busy trigger ignored", int'(csr[0]), 0);
    chk("R10 triggered result", int'(result), 10'h155);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule